// File: doc/BRIEF.md
# Preloadable Timer/Event Counter

This block is an up-counter that software drives through a small byte-wide register port. It runs in one of three modes. As a timer it counts ticks from an internal clock enable that has passed through a programmable prescaler. As an event counter it counts active transitions on an external pin. In pulse-width capture mode it counts prescaled ticks while the pin sits at a chosen level, and it stops itself when that level ends. The counter width is a parameter, 8 or 16 bits.

A preload register holds the reload value. On each overflow from all ones the counter reloads from it, and a one-cycle interrupt pulse is raised. A preload write goes into the counter at once while the timer is stopped. While the timer runs, the new value waits in the preload register until the next overflow. The external pin is synchronised into the system clock domain before it is used. Reading the low count byte captures the high byte, so that a 16-bit value can be read coherently as two bytes.

Top module: `evt_timer`

## Requirements
- R1: After reset the control register reads 0x00, the counter is zero and the interrupt output is low. The preload register is not reset.
- R2: The register map is as follows. Address 0 is the control register, for both read and write. Address 1 writes the preload low byte and reads the live counter low byte. Address 2 writes the preload high byte and reads the latched counter high byte. Address 3 reads 0x00, and writes to it are ignored.
- R3: When the counter holds all ones, the next count tick reloads it from the preload register. The interrupt output is then high for exactly the following cycle, and it pulses again on every further overflow.
- R4: A preload write while control bit 4 (run) is 0 copies the updated preload value into the counter on the same clock edge.
- R5: A preload write while run is 1 leaves the counter untouched. The new value enters the counter only at the next overflow.
- R6: Control bits [7:6] choose the mode: 2'b10 timer, 2'b01 event counter, 2'b11 pulse-width capture. In timer mode, with run set, the counter advances once per prescaler output tick.
- R7: The prescaler passes one selected source tick out of every 2^bits[2:0] (1 to 128) and restarts from zero whenever run is 0.
- R8: Control bit 5 picks the internal tick source: 0 selects tickSrcA and 1 selects tickSrcB.
- R9: In event mode, each rising pin edge (bit 3 = 0) or falling pin edge (bit 3 = 1) adds one. The edge takes effect three clock edges after the pin changes. The prescaler bits have no effect in this mode.
- R10: In capture mode, prescaled ticks are counted only while the synchronised pin is at its active level: high when bit 3 = 0, low when bit 3 = 1. At the edge that ends the active level, run clears by itself and the count freezes.
- R11: With run at 0, or with mode 2'b00, the counter does not advance and no interrupt occurs.
- R12: A read strobe at address 1 latches the counter's high byte. A later read at address 2 returns that latched byte, even though the counter has moved on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (latches the high byte at address 1) |
| addr | input | 2 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational from addr |
| tickSrcA | input | 1 | Internal tick enable, source 0 |
| tickSrcB | input | 1 | Internal tick enable, source 1 |
| evtPin | input | 1 | External timer pin, asynchronous |
| irq | output | 1 | One-cycle overflow interrupt pulse |

## Verification
A behavioural model in the bench is compared against the read data and the interrupt on every clock. The bench targets the following corner cases. A running preload write is one: a design that loads it at once would show a jump in the count. Back-to-back overflows with a preload of all ones are another: a design that merges them would miss interrupt pulses. The bench also checks the exact pin-to-count latency of the synchroniser, where an extra or missing stage shifts every event count by a cycle. It checks the self-stop at the end of a capture, where a design that keeps running would let the count drift. Finally, it reads the high byte after the counter has moved on; an unlatched read would return the new byte instead of the captured one.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  typedef enum logic [1:0] {
    MODE_OFF     = 2'b00,
    MODE_EVENT   = 2'b01,
    MODE_TIMER   = 2'b10,
    MODE_CAPTURE = 2'b11
  } tmr_mode_e;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_BYTE_LO = 2'd1;
  localparam logic [1:0] ADDR_BYTE_HI = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic tick;     // advance counter
    logic plWrLo;   // preload low byte write
    logic plWrHi;   // preload high byte write
    logic loadNow;  // copy preload into counter (stopped)
    logic latchHi;  // capture high byte for coherent read
  } dp_strobe_t;

endpackage

// File: rtl/evt_timer_ctrl.sv
module evt_timer_ctrl
  import evt_timer_pkg::*;
#(
  parameter int PSC_SEL_W   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [1:0] addr,
  input  logic [7:0] wrData,
  input  logic [1:0] srcTick,
  input  logic       evtPin,
  output logic [7:0] ctrlVal,
  output dp_strobe_t strb
);

  localparam int PSC_CNT_W = (1 << PSC_SEL_W) - 1;

  logic [7:0]             ctrlQ;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic [PSC_CNT_W-1:0]   pscQ;
  logic [PSC_CNT_W-1:0]   pscMask;

  tmr_mode_e mode;
  logic runBit, edgeSel, selTick, pscTick;
  logic pinLvl, pinRise, pinFall, actEdge, inactEdge, pinActive;
  logic ctrlWr, capClr;

  assign mode    = tmr_mode_e'(ctrlQ[7:6]);
  assign runBit  = ctrlQ[4];
  assign edgeSel = ctrlQ[3];
  assign selTick = srcTick[ctrlQ[5]];
  assign ctrlWr  = wrEn && (addr == ADDR_CTRL);

  // pin synchroniser and edge detector
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], evtPin};
      prevQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign pinLvl    = syncQ[SYNC_STAGES-1];
  assign pinRise   = pinLvl & ~prevQ;
  assign pinFall   = ~pinLvl & prevQ;
  assign actEdge   = edgeSel ? pinFall : pinRise;
  assign inactEdge = edgeSel ? pinRise : pinFall;
  assign pinActive = pinLvl ^ edgeSel;

  // prescaler: one output per 2^sel source ticks
  assign pscMask = (PSC_CNT_W'(1) << ctrlQ[PSC_SEL_W-1:0]) - PSC_CNT_W'(1);
  assign pscTick = runBit & selTick & ((pscQ & pscMask) == pscMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          pscQ <= '0;
    else if (!runBit)   pscQ <= '0;
    else if (selTick)   pscQ <= pscQ + PSC_CNT_W'(1);
  end

  assign capClr = runBit && (mode == MODE_CAPTURE) && inactEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        ctrlQ <= '0;
    else if (ctrlWr)  ctrlQ <= wrData;
    else if (capClr)  ctrlQ[4] <= 1'b0;
  end

  always_comb begin
    strb = '0;
    unique case (mode)
      MODE_TIMER:   strb.tick = pscTick;
      MODE_EVENT:   strb.tick = runBit & actEdge;
      MODE_CAPTURE: strb.tick = pscTick & pinActive;
      default:      strb.tick = 1'b0;
    endcase
    strb.plWrLo  = wrEn && (addr == ADDR_BYTE_LO);
    strb.plWrHi  = wrEn && (addr == ADDR_BYTE_HI);
    strb.loadNow = (strb.plWrLo | strb.plWrHi) & ~runBit;
    strb.latchHi = rdEn && (addr == ADDR_BYTE_LO);
  end

  assign ctrlVal = ctrlQ;

  // R11
  stopped_no_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runBit |-> !strb.tick);

  // R10
  capture_self_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (capClr && !ctrlWr) |=> !ctrlVal[4]);

  // R7
  psc_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!runBit && !ctrlWr) |=> (pscQ == '0) && !strb.tick);

endmodule

// File: rtl/evt_timer_dp.sv
module evt_timer_dp
  import evt_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  dp_strobe_t strb,
  input  logic [7:0] wrData,
  input  logic [1:0] addr,
  input  logic [7:0] ctrlVal,
  output logic [7:0] rdData,
  output logic       irq
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] plQ;
  logic [CNT_W-1:0] plNext;
  logic [7:0]       rdHi;
  logic             irqQ;
  logic             atMax;

  generate
    if (CNT_W > 8) begin : g_wide
      logic [7:0] hiQ;

      always_comb begin
        plNext = plQ;
        if (strb.plWrLo) plNext[7:0]       = wrData;
        if (strb.plWrHi) plNext[CNT_W-1:8] = wrData[CNT_W-9:0];
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             hiQ <= '0;
        else if (strb.latchHi) hiQ <= cntQ[CNT_W-1:8];
      end

      assign rdHi = hiQ;

      // R12
      hi_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
        strb.latchHi |=> hiQ == $past(cntQ[CNT_W-1:8]));
    end else begin : g_narrow
      always_comb begin
        plNext = plQ;
        if (strb.plWrLo) plNext = wrData;
      end
      assign rdHi = 8'h00;
    end
  endgenerate

  // preload is deliberately left without reset
  always_ff @(posedge clk) plQ <= plNext;

  assign atMax = (cntQ == CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      irqQ <= 1'b0;
    end else begin
      irqQ <= strb.tick & atMax;
      if (strb.loadNow)   cntQ <= plNext;
      else if (strb.tick) cntQ <= atMax ? plQ : cntQ + CNT_W'(1);
    end
  end

  always_comb begin
    unique case (addr)
      ADDR_CTRL:    rdData = ctrlVal;
      ADDR_BYTE_LO: rdData = cntQ[7:0];
      ADDR_BYTE_HI: rdData = rdHi;
      default:      rdData = 8'h00;
    endcase
  end

  assign irq = irqQ;

  // R3
  reload_on_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqQ |-> cntQ == $past(plQ));

  // R4
  load_stopped_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadNow |=> cntQ == $past(plNext));

  // R5
  held_preload_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.plWrLo || strb.plWrHi) && !strb.loadNow && !strb.tick) |=> $stable(cntQ));

endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PSC_SEL_W   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [1:0] addr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       tickSrcA,
  input  logic       tickSrcB,
  input  logic       evtPin,
  output logic       irq
);

  dp_strobe_t strb;
  logic [7:0] ctrlVal;

  evt_timer_ctrl #(
    .PSC_SEL_W  (PSC_SEL_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .addr   (addr),
    .wrData (wrData),
    .srcTick({tickSrcB, tickSrcA}),
    .evtPin (evtPin),
    .ctrlVal(ctrlVal),
    .strb   (strb)
  );

  evt_timer_dp #(
    .CNT_W(CNT_W)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (wrData),
    .addr   (addr),
    .ctrlVal(ctrlVal),
    .rdData (rdData),
    .irq    (irq)
  );

endmodule

// File: tb/evt_timer_tb_top.sv
module evt_timer_tb_top;

  localparam int MAXV = 16'hFFFF;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0, rdEn = 1'b0;
  logic [1:0] addr = 2'd1;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       tickSrcA = 1'b0, tickSrcB = 1'b0, evtPin = 1'b0;
  logic       irq;

  int nChk = 0, nErr = 0;
  string curReq = "R1";
  bit skipRd = 0;
  bit finished = 0;

  // reference model state
  int mCtrl, mPl, mCnt, mIrq, mHi, mPsc;
  bit s1, s2, s3;

  evt_timer dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .tickSrcA(tickSrcA),
    .tickSrcB(tickSrcB), .evtPin(evtPin), .irq(irq)
  );

  always #2 clk = ~clk;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCtrl = 0; mPl = 0; mCnt = 0; mIrq = 0; mHi = 0; mPsc = 0;
      s1 = 0; s2 = 0; s3 = 0;
    end else begin
      int run, mode, eb, div, src, nPl, nCnt, nCtrl, nPsc;
      bit rise, fall, act, inact, lvl, ptick, tick;
      run  = (mCtrl >> 4) & 1;
      mode = (mCtrl >> 6) & 3;
      eb   = (mCtrl >> 3) & 1;
      div  = 1 << (mCtrl & 7);
      src  = ((mCtrl >> 5) & 1) ? tickSrcB : tickSrcA;
      rise = s2 && !s3;
      fall = !s2 && s3;
      act  = eb ? fall : rise;
      inact = eb ? rise : fall;
      lvl  = (s2 != eb);
      ptick = run && src && ((mPsc % div) == div - 1);
      case (mode)
        2: tick = ptick;
        1: tick = run && act;
        3: tick = ptick && lvl;
        default: tick = 0;
      endcase
      nPl = mPl;
      if (wrEn && addr == 1) nPl = (mPl & 16'hFF00) | wrData;
      if (wrEn && addr == 2) nPl = (mPl & 16'h00FF) | (int'(wrData) << 8);
      nCnt = mCnt;
      if (wrEn && (addr == 1 || addr == 2) && !run) nCnt = nPl;
      else if (tick) nCnt = (mCnt == MAXV) ? mPl : mCnt + 1;
      mIrq = (tick && mCnt == MAXV) ? 1 : 0;
      if (rdEn && addr == 1) mHi = (mCnt >> 8) & 255;
      nCtrl = mCtrl;
      if (wrEn && addr == 0) nCtrl = wrData;
      else if (run && mode == 3 && inact) nCtrl = mCtrl & ~16;
      nPsc = !run ? 0 : (src ? (mPsc + 1) % 128 : mPsc);
      s3 = s2; s2 = s1; s1 = evtPin;
      mPl = nPl; mCnt = nCnt; mCtrl = nCtrl; mPsc = nPsc;
    end
  end

  task automatic check(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int expRd();
    case (addr)
      2'd0: return mCtrl;
      2'd1: return mCnt & 255;
      2'd2: return mHi;
      default: return 0;
    endcase
  endfunction

  // compare, then advance one clock; returns just after a falling edge
  task automatic cyc();
    #1;
    if (!skipRd) check(curReq, rdData, expRd());
    check(curReq, irq, mIrq);
    skipRd = 0;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wrReg(logic [1:0] a, logic [7:0] d);
    wrEn = 1; addr = a; wrData = d;
    cyc();
    wrEn = 0; addr = 2'd1;
  endtask

  task automatic setPl(logic [7:0] hi, logic [7:0] lo);
    wrReg(2'd2, hi);
    wrReg(2'd1, lo);
  endtask

  task automatic pinPulses(int n, int halfLen);
    for (int i = 0; i < n; i++) begin
      evtPin = 1; idle(halfLen);
      evtPin = 0; idle(halfLen);
    end
  endtask

  initial begin
    int pulses;
    @(negedge clk);
    // R1 reset values
    curReq = "R1";
    idle(3);
    rstN = 1;
    addr = 2'd0; cyc(); check("R1", rdData, 0);
    addr = 2'd1; cyc(); check("R1", rdData, 0); check("R1", irq, 0);

    // R2/R4: preload writes while stopped go to the counter
    curReq = "R4";
    wrEn = 1; addr = 2'd2; wrData = 8'h12; cyc();
    wrEn = 0; addr = 2'd1; skipRd = 1;
    wrReg(2'd1, 8'h34);
    check("R4", rdData, 8'h34);
    curReq = "R2";
    addr = 2'd3; cyc(); check("R2", rdData, 0);
    wrReg(2'd3, 8'hAA);
    addr = 2'd0; cyc(); check("R2", rdData, 0);
    addr = 2'd1;

    // R12 coherent high byte
    curReq = "R12";
    rdEn = 1; cyc(); rdEn = 0;
    addr = 2'd2; cyc(); check("R12", rdData, 8'h12);
    addr = 2'd1;

    // R6/R3 timer mode, divide by one, reload FFF8
    curReq = "R3";
    setPl(8'hFF, 8'hF8);
    tickSrcA = 1;
    wrReg(2'd0, 8'h90);
    pulses = 0;
    for (int i = 0; i < 31; i++) begin
      #1; if (irq) pulses++;
      cyc();
    end
    check("R3", pulses, 3);
    curReq = "R6";
    idle(5);

    // R12 latched byte stays while counter moves
    curReq = "R12";
    rdEn = 1; cyc(); rdEn = 0;
    idle(9);
    addr = 2'd2; idle(3); addr = 2'd1;

    // R5 running preload write held until overflow
    curReq = "R5";
    wrReg(2'd1, 8'hF0);
    idle(40);

    // R11 stop freezes, mode 00 inert
    curReq = "R11";
    wrReg(2'd0, 8'h80);
    idle(10);
    wrReg(2'd0, 8'h10);
    idle(10);

    // R3 back-to-back overflows with preload all ones
    curReq = "R3";
    wrReg(2'd0, 8'h00);
    setPl(8'hFF, 8'hFF);
    wrReg(2'd0, 8'h90);
    idle(6);

    // R7 prescaler /8 and restart
    curReq = "R7";
    wrReg(2'd0, 8'h00);
    setPl(8'h00, 8'h00);
    wrReg(2'd0, 8'h93);
    idle(40);
    for (int i = 0; i < 60; i++) begin
      tickSrcA = (i % 3 == 0); cyc();
    end
    tickSrcA = 1;
    wrReg(2'd0, 8'h83);
    idle(3);
    wrReg(2'd0, 8'h95);
    idle(70);

    // R8 source select
    curReq = "R8";
    wrReg(2'd0, 8'hB0);
    tickSrcB = 0; idle(10);
    tickSrcB = 1; idle(5);
    tickSrcA = 0; idle(5);
    tickSrcB = 0;

    // R9 event counting, rising then falling, prescaler bits ignored
    curReq = "R9";
    wrReg(2'd0, 8'h00);
    setPl(8'h00, 8'h00);
    wrReg(2'd0, 8'h57);
    pinPulses(6, 3);
    idle(4);
    check("R9", rdData, 6);
    wrReg(2'd0, 8'h5F);
    pinPulses(4, 2);
    evtPin = 1; idle(4);
    check("R9", rdData, 10);
    evtPin = 0; idle(4);

    // R10 capture, active high then active low
    curReq = "R10";
    wrReg(2'd0, 8'h00);
    setPl(8'h00, 8'h00);
    tickSrcA = 1;
    wrReg(2'd0, 8'hD0);
    idle(5);
    evtPin = 1; idle(20);
    evtPin = 0; idle(10);
    check("R10", rdData, 20);
    addr = 2'd0; cyc(); check("R10", rdData, 8'hC0); addr = 2'd1;
    evtPin = 1; idle(6);
    setPl(8'h00, 8'h00);
    wrReg(2'd0, 8'hD9);
    evtPin = 0; idle(24);
    evtPin = 1; idle(8);
    addr = 2'd0; cyc(); check("R10", rdData, 8'hC9); addr = 2'd1;
    idle(3);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nErr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChk++; nErr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nErr);
      $finish;
    end
  end

endmodule